// File: doc/BRIEF.md
# Dual-Compare PWM Generator with Deferred Register Commit

This block is one pulse-width-modulation channel pair. A 16-bit counter runs in one of two modes. In descending mode it counts down and reloads from a period value. In symmetric mode it counts up to the period and then back down. Two compare values are checked against the counter, and each one produces its own raw output: `out_a` from the A compare and `out_b` from the B compare. Pulse widths are measured in counter clock ticks.

Software writes the period and compare values through a simple write port. These writes land in a queued copy only. The values in use change only on a counter-zero tick that follows an explicit update request, so a new period and new widths always start together at a cycle boundary. A sync input forces the counter back to zero, which lines up the time base with other channels. A one-clock strobe marks each counter-zero tick. A read port returns the queued values, not the ones in use.

Top module: `pwm_pair_gen`

## Requirements
- R1: In descending mode (`wr_sel`=3 with `wr_data[0]`=0), the counter goes from the active period P down to 0 and then reloads P. The period is therefore P+1 ticks. An output is high while the counter is strictly above its compare value C, which gives P−C high ticks per period.
- R2: In symmetric mode (`wr_sel`=3 with `wr_data[0]`=1), the counter rises from 1 to P and then falls from P−1 to 0. The period is therefore 2·P ticks. On the rise an output is high while counter > C. On the fall it is high while counter ≥ C. This gives 2·(P−C) high ticks.
- R3: `out_a` follows compare A and `out_b` follows compare B. A compare value at or above P keeps its output low for the whole period. A compare of 0 in symmetric mode keeps the output high for the whole period.
- R4: Write port selector encoding: 0 = period, 1 = compare A, 2 = compare B, 3 = mode bit. Period and compare writes go to the queued copy only. The active values, and therefore the waveforms, do not change without an update request. The mode bit takes effect at once.
- R5: `upd_req` in a cycle where the counter is not zero sets `upd_pending`. On the next counter-zero tick the queued values become active and `upd_pending` clears.
- R6: `sync_req` forces the counter to 0 at the next clock edge. Counting then resumes normally from there.
- R7: `rd_data` returns the queued value chosen by `rd_sel` (same encoding as R4, with the mode bit in bit 0). This value can differ from the active one until a commit.
- R8: `zero_evt` is high for exactly one clock on each counter-zero tick while the period is nonzero.
- R9: An `upd_req` in a counter-zero cycle commits at that edge and leaves `upd_pending` low. A write in the commit cycle stays queued and is not part of that commit.
- R10: After a synchronous active-low reset, all values are 0, the mode is descending, both outputs are low, `upd_pending` is low and `zero_evt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the queued registers |
| wr_sel | input | 2 | Write target: 0 period, 1 compare A, 2 compare B, 3 mode |
| wr_data | input | 16 | Write value |
| upd_req | input | 1 | Request a commit on the next counter-zero tick |
| sync_req | input | 1 | Force the counter to zero |
| rd_sel | input | 2 | Read target, same encoding as wr_sel |
| rd_data | output | 16 | Queued value of the selected register |
| out_a | output | 1 | Raw output from compare A |
| out_b | output | 1 | Raw output from compare B |
| zero_evt | output | 1 | One-clock strobe on each counter-zero tick |
| upd_pending | output | 1 | An update request is waiting for the next zero |

## Verification
Two events can fall in the same cycle: the counter-zero tick that commits queued values, and a fresh update request or register write. The bench waits until it sees `zero_evt` high at a falling edge. It then drives `upd_req` together with a new compare A value in that same cycle. It judges the result in two ways. First, `upd_pending` must stay low, showing the commit happened at once. Second, the measured widths over the next full period must show that an earlier queued compare B was committed while the compare A written in the collision cycle was not.

// File: rtl/pwm_pair_pkg.sv
// Package: shared selector and mode encodings for the PWM channel pair.
// Assumes a 2-bit register selector and a 1-bit mode control.
package pwm_pair_pkg;

    typedef enum logic [1:0] {
        SEL_PERIOD = 2'd0,
        SEL_CMP_A  = 2'd1,
        SEL_CMP_B  = 2'd2,
        SEL_MODE   = 2'd3
    } reg_sel_e;

    typedef enum logic {
        MODE_DESC = 1'b0,
        MODE_SYMM = 1'b1
    } count_mode_e;

    localparam int NUM_CMP = 2;

endpackage

// File: rtl/pwm_shadow_bank.sv
// Module: queued and active copies of the period and compare values.
// The write port fills the queued copy. A commit copies queued to active
// when the counter sits at zero and an update request is pending or is
// arriving in that cycle. The mode bit is not queued.
// Assumes at_zero comes from the counter register of the same clock domain.
module pwm_shadow_bank
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [W-1:0]              wr_data,
    input  logic                      upd_req,
    input  logic                      at_zero,
    input  logic [1:0]                rd_sel,
    output logic [W-1:0]              rd_data,
    output logic [W-1:0]              act_period,
    output logic [NUM_CMP-1:0][W-1:0] act_cmp,
    output logic [W-1:0]              period_next,
    output logic                      pending,
    output count_mode_e               mode
);

    logic [W-1:0]              shd_period;
    logic [NUM_CMP-1:0][W-1:0] shd_cmp;
    logic                      commit;
    reg_sel_e                  wsel;

    assign wsel   = reg_sel_e'(wr_sel);
    assign commit = at_zero && (pending || upd_req);

    // Reload value seen by the counter: new period when committing now.
    assign period_next = commit ? shd_period : act_period;

    // Queued register file, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_period <= '0;
            shd_cmp    <= '0;
            mode       <= MODE_DESC;
        end else if (wr_en) begin
            case (wsel)
                SEL_PERIOD: shd_period <= wr_data;
                SEL_CMP_A:  shd_cmp[0] <= wr_data;
                SEL_CMP_B:  shd_cmp[1] <= wr_data;
                default:    mode       <= count_mode_e'(wr_data[0]);
            endcase
        end
    end

    // Active copy, loaded from the pre-write queued values on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_period <= '0;
            act_cmp    <= '0;
        end else if (commit) begin
            act_period <= shd_period;
            act_cmp    <= shd_cmp;
        end
    end

    // Update-request flag: set by a request, cleared by the commit.
    always_ff @(posedge clk) begin
        if (!rst_n)       pending <= 1'b0;
        else if (commit)  pending <= 1'b0;
        else if (upd_req) pending <= 1'b1;
    end

    // Read-back of the queued copy.
    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_PERIOD: rd_data = shd_period;
            SEL_CMP_A:  rd_data = shd_cmp[0];
            SEL_CMP_B:  rd_data = shd_cmp[1];
            default:    rd_data = {{(W-1){1'b0}}, mode};
        endcase
    end

    // R4/R5: active values change only right after a counter-zero tick.
    a_r4_commit_only_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(act_period) || !$stable(act_cmp)) |-> $past(at_zero));

    // R5: a pending request is consumed by the zero tick.
    a_r5_pending_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && at_zero) |=> !pending);

    // R5: a request away from zero is remembered.
    a_r5_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && !at_zero) |=> pending);

    // R9: a request in a zero cycle commits at once and leaves no flag.
    a_r9_request_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && at_zero) |=> !pending);

endmodule

// File: rtl/pwm_timebase.sv
// Module: counter for the PWM pair, descending or symmetric.
// Descending: P..0, reload from period_next. Symmetric: 1..P on the rise,
// P-1..0 on the fall; the zero tick belongs to the fall. A zero period
// parks the counter at 0. Sync forces 0 and the falling direction.
// Assumes act_period changes only on a zero tick.
module pwm_timebase
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  count_mode_e mode,
    input  logic        sync_req,
    input  logic [W-1:0] period_next,
    input  logic [W-1:0] act_period,
    output logic [W-1:0] cnt,
    output logic         falling,
    output logic         at_zero
);

    assign at_zero = (cnt == '0);

    // Counter and direction update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            falling <= 1'b1;
        end else if (sync_req) begin
            cnt     <= '0;
            falling <= 1'b1;
        end else if (mode == MODE_DESC) begin
            cnt     <= at_zero ? period_next : cnt - W'(1);
            falling <= 1'b1;
        end else if (at_zero) begin
            cnt     <= (period_next == '0) ? '0 : W'(1);
            falling <= (period_next == '0);
        end else if (!falling && cnt < act_period) begin
            cnt     <= cnt + W'(1);
        end else begin
            cnt     <= cnt - W'(1);
            falling <= 1'b1;
        end
    end

    // R1/R2: the counter never leaves the range 0..period.
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= act_period);

    // R6: sync brings the counter to zero at the next edge.
    a_r6_sync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> at_zero);

endmodule

// File: rtl/pwm_compare.sv
// Module: one compare unit. High while the counter is above the compare
// value. In symmetric mode, equality also counts on the falling half.
// Assumes cnt never exceeds act_period.
module pwm_compare
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  count_mode_e  mode,
    input  logic [W-1:0] cnt,
    input  logic         falling,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] act_period,
    output logic         out
);

    // Output decision.
    always_comb begin
        out = (cnt > cmp) || (mode == MODE_SYMM && falling && cnt == cmp);
    end

    // R3: a compare value above the period keeps the output low.
    a_r3_low_above_period: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp > act_period) |-> !out);

endmodule

// File: rtl/pwm_pair_gen.sv
// Module: top of the PWM channel pair. It ties the queued/active register
// bank, the counter and one compare unit per output together.
// Assumes a single clock; all inputs are synchronous to clk.
module pwm_pair_gen
    import pwm_pair_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         upd_req,
    input  logic         sync_req,
    input  logic [1:0]   rd_sel,
    output logic [W-1:0] rd_data,
    output logic         out_a,
    output logic         out_b,
    output logic         zero_evt,
    output logic         upd_pending
);

    logic [W-1:0]              act_period;
    logic [NUM_CMP-1:0][W-1:0] act_cmp;
    logic [W-1:0]              period_next;
    logic [W-1:0]              cnt;
    logic                      falling;
    logic                      at_zero;
    logic [NUM_CMP-1:0]        outs;
    count_mode_e               mode;

    pwm_shadow_bank #(.W(W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_req(upd_req), .at_zero(at_zero),
        .rd_sel(rd_sel), .rd_data(rd_data), .act_period(act_period),
        .act_cmp(act_cmp), .period_next(period_next),
        .pending(upd_pending), .mode(mode)
    );

    pwm_timebase #(.W(W)) u_tb (
        .clk(clk), .rst_n(rst_n), .mode(mode), .sync_req(sync_req),
        .period_next(period_next), .act_period(act_period),
        .cnt(cnt), .falling(falling), .at_zero(at_zero)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        pwm_compare #(.W(W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .mode(mode), .cnt(cnt),
            .falling(falling), .cmp(act_cmp[g]),
            .act_period(act_period), .out(outs[g])
        );
    end

    assign out_a    = outs[0];
    assign out_b    = outs[1];
    assign zero_evt = at_zero;

    // R8: with a nonzero period the zero strobe lasts one clock.
    a_r8_zero_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && !sync_req) |=> (act_period == '0) || !zero_evt);

endmodule

// File: tb/pwm_pair_gen_test.sv
// Bench: directed scenarios for the PWM channel pair, one task each.
module pwm_pair_gen_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [W-1:0] wr_data = '0;
    logic         upd_req = 1'b0;
    logic         sync_req = 1'b0;
    logic [1:0]   rd_sel = '0;
    logic [W-1:0] rd_data;
    logic         out_a, out_b, zero_evt, upd_pending;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pwm_pair_gen #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .upd_req(upd_req), .sync_req(sync_req),
        .rd_sel(rd_sel), .rd_data(rd_data), .out_a(out_a), .out_b(out_b),
        .zero_evt(zero_evt), .upd_pending(upd_pending)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [1:0] sel, input int val);
        wr_en = 1'b1; wr_sel = sel; wr_data = W'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_upd();
        upd_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0;
    endtask

    task automatic wait_zero();
        while (!zero_evt) @(negedge clk);
    endtask

    task automatic wait_nonzero();
        while (zero_evt) @(negedge clk);
    endtask

    task automatic wait_commit();
        while (upd_pending) @(negedge clk);
    endtask

    task automatic count_win(input int n, output int ca, output int cb, output int cz);
        ca = 0; cb = 0; cz = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ca += int'(out_a); cb += int'(out_b); cz += int'(zero_evt);
        end
    endtask

    task automatic t_reset();
        chk("R10 out_a", int'(out_a), 0);
        chk("R10 out_b", int'(out_b), 0);
        chk("R10 pending", int'(upd_pending), 0);
        chk("R10 zero_evt", int'(zero_evt), 1);
        for (int s = 0; s < 4; s++) begin
            rd_sel = 2'(s);
            #1 chk("R10 rd_data", int'(rd_data), 0);
        end
    endtask

    task automatic t_desc_basic();
        int ca, cb, cz;
        wr(2'd0, 9); wr(2'd1, 3); wr(2'd2, 7);
        rd_sel = 2'd0;
        #1 chk("R7 queued period", int'(rd_data), 9);
        chk("R4 active period still zero", int'(zero_evt), 1);
        pulse_upd();
        wait_commit();
        count_win(20, ca, cb, cz);
        chk("R1 width A", ca, 12);
        chk("R1 width B", cb, 4);
        chk("R8 zero strobes", cz, 2);
    endtask

    task automatic t_no_request();
        int ca, cb, cz;
        wr(2'd1, 5);
        rd_sel = 2'd1;
        #1 chk("R7 queued cmp A", int'(rd_data), 5);
        count_win(20, ca, cb, cz);
        chk("R4 width A unchanged", ca, 12);
    endtask

    task automatic t_deferred();
        int ca, cb, cz;
        wait_nonzero();
        pulse_upd();
        chk("R5 pending set", int'(upd_pending), 1);
        wait_zero();
        chk("R5 pending at zero", int'(upd_pending), 1);
        @(negedge clk);
        chk("R5 pending cleared", int'(upd_pending), 0);
        count_win(10, ca, cb, cz);
        chk("R5 new width A", ca, 4);
        chk("R3 width B", cb, 2);
    endtask

    task automatic t_sync();
        int ca, cb, cz;
        wait_nonzero();
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        chk("R6 zero after sync", int'(zero_evt), 1);
        count_win(9, ca, cb, cz);
        chk("R6 no zero mid period", cz, 0);
        count_win(1, ca, cb, cz);
        chk("R6 next zero", cz, 1);
    endtask

    task automatic t_collision();
        int ca, cb, cz;
        wait_nonzero();
        wr(2'd2, 1);
        wait_zero();
        upd_req = 1'b1; wr_en = 1'b1; wr_sel = 2'd1; wr_data = W'(8);
        @(negedge clk);
        upd_req = 1'b0; wr_en = 1'b0;
        chk("R9 no pending after zero request", int'(upd_pending), 0);
        rd_sel = 2'd1;
        #1 chk("R9 collision write queued", int'(rd_data), 8);
        count_win(10, ca, cb, cz);
        chk("R9 cmp A not committed", ca, 4);
        chk("R9 cmp B committed", cb, 8);
    endtask

    task automatic t_symm();
        int ca, cb, cz;
        wr(2'd3, 1);
        rd_sel = 2'd3;
        #1 chk("R7 mode readback", int'(rd_data), 1);
        wr(2'd0, 6); wr(2'd1, 2); wr(2'd2, 6);
        upd_req = 1'b1; sync_req = 1'b1;
        @(negedge clk);
        upd_req = 1'b0; sync_req = 1'b0;
        wait_commit();
        count_win(24, ca, cb, cz);
        chk("R2 width A", ca, 16);
        chk("R3 cmp equal period low", cb, 0);
        chk("R2 period", cz, 2);
    endtask

    task automatic t_symm_edges();
        int ca, cb, cz;
        wr(2'd1, 0); wr(2'd2, 20);
        wait_nonzero();
        pulse_upd();
        wait_commit();
        count_win(24, ca, cb, cz);
        chk("R3 cmp zero always high", ca, 24);
        chk("R3 cmp above period low", cb, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_desc_basic();
        t_no_request();
        t_deferred();
        t_sync();
        t_collision();
        t_symm();
        t_symm_edges();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule